// File: doc/BRIEF.md
# Sticky User-Context Restriction Mask

This block holds the restriction masks for the user-context field of a key-operation engine. A set bit bars that position of the user context from use. A clear bit allows it. There are two masks. The soft mask can be written and cleared freely. The lock mask only accumulates ones, and nothing but the asynchronous reset clears it. The OR of the two masks is the effective restriction, and the block publishes it as a read-only status vector.

A global write-protect input gates every register write. While it is high, no write changes either mask. The key engine presents a requested context on the check port, and the block reports at once whether that request touches any restricted bit.

Top module: `ucr_guard`

## Requirements
- R1: After `rst_ni` is asserted, the soft mask, the lock mask and `status_o` are all zero.
- R2: A write to offset 0x0 while `wp_en_i` is low replaces the soft mask with `wdata_i` at the next clock edge, so bits can be cleared as well as set.
- R3: While `wp_en_i` is high, no write changes the soft mask or the lock mask.
- R4: A write to offset 0x4 while `wp_en_i` is low ORs `wdata_i` into the lock mask at the next clock edge. A zero data bit leaves that lock bit as it was.
- R5: Once a lock bit is set, no register access clears it. Only a low level on `rst_ni` clears it, and a reset wins over a lock write in the same cycle.
- R6: `status_o` equals the soft mask OR the lock mask. It reflects a write from the clock edge that performs the write.
- R7: Offset 0x8 returns the status vector on a read and ignores writes. Every other offset reads as zero and ignores writes.
- R8: `chk_viol_o` is high in the same cycle as `chk_valid_i` exactly when `chk_ctx_i & status_o` is nonzero. It is low whenever `chk_valid_i` is low.
- R9: When `req_i` is high and `we_i` is low, `rdata_o` carries the addressed register in the same cycle: the soft mask at 0x0 and the lock mask at 0x4. Otherwise `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, clears both masks |
| wp_en_i | input | 1 | Write protect; high blocks all register writes |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Access is a write when high |
| addr_i | input | ADDR_W (4) | Byte offset of the register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, combinational |
| status_o | output | DATA_W (32) | Effective restriction, soft OR lock |
| chk_valid_i | input | 1 | Context check strobe |
| chk_ctx_i | input | DATA_W (32) | Requested user context |
| chk_viol_o | output | 1 | Requested context uses a restricted bit |

## Verification
Read data and the violation flag are combinational. They are due in the cycle of their strobe and are sampled 1 ns after the falling edge on which the inputs change. A write takes effect at the next rising edge, so `status_o` and any readback show it from the following falling-edge sample on. The bench reference model updates its masks at each rising edge, or at once on reset. It is compared every cycle on read data, status and the violation flag. That comparison covers the case of a reset arriving together with a lock write.

// File: rtl/ucr_pkg.sv
package ucr_pkg;
  localparam int unsigned OFF_SOFT = 'h0;
  localparam int unsigned OFF_LOCK = 'h4;
  localparam int unsigned OFF_STAT = 'h8;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_SOFT = 2'd1,
    SEL_LOCK = 2'd2,
    SEL_STAT = 2'd3
  } ucr_sel_e;
endpackage

// File: rtl/ucr_reg_if.sv
module ucr_reg_if
  import ucr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic              wp_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] soft_i,
  input  logic [DATA_W-1:0] lock_i,
  input  logic [DATA_W-1:0] stat_i,
  output logic              soft_we_o,
  output logic              lock_we_o,
  output logic [DATA_W-1:0] rdata_o
);
  ucr_sel_e sel;
  logic     wr_ok;
  logic     rd;

  always_comb begin
    if (addr_i == ADDR_W'(OFF_SOFT))      sel = SEL_SOFT;
    else if (addr_i == ADDR_W'(OFF_LOCK)) sel = SEL_LOCK;
    else if (addr_i == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
    else                                  sel = SEL_NONE;
  end

  assign wr_ok     = req_i && we_i && !wp_en_i;
  assign rd        = req_i && !we_i;
  assign soft_we_o = wr_ok && (sel == SEL_SOFT);
  assign lock_we_o = wr_ok && (sel == SEL_LOCK);

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (sel)
        SEL_SOFT: rdata_o = soft_i;
        SEL_LOCK: rdata_o = lock_i;
        SEL_STAT: rdata_o = stat_i;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/ucr_soft_mask.sv
module ucr_soft_mask #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/ucr_lock_mask.sv
module ucr_lock_mask #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o
);
  // one set-only flop per bit; only reset clears
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   mask_o[b] <= 1'b0;
      else if (we_i && wdata_i[b])   mask_o[b] <= 1'b1;
    end
  end
endmodule

// File: rtl/ucr_ctx_check.sv
module ucr_ctx_check #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              valid_i,
  input  logic [DATA_W-1:0] ctx_i,
  input  logic [DATA_W-1:0] restrict_i,
  output logic              viol_o
);
  assign viol_o = valid_i && (|(ctx_i & restrict_i));
endmodule

// File: rtl/ucr_guard.sv
module ucr_guard #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_en_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] status_o,
  input  logic              chk_valid_i,
  input  logic [DATA_W-1:0] chk_ctx_i,
  output logic              chk_viol_o
);
  logic [DATA_W-1:0] soft_q;
  logic [DATA_W-1:0] lock_q;
  logic              soft_we;
  logic              lock_we;

  ucr_reg_if #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_if (
    .req_i    (req_i),
    .we_i     (we_i),
    .wp_en_i  (wp_en_i),
    .addr_i   (addr_i),
    .soft_i   (soft_q),
    .lock_i   (lock_q),
    .stat_i   (status_o),
    .soft_we_o(soft_we),
    .lock_we_o(lock_we),
    .rdata_o  (rdata_o)
  );

  ucr_soft_mask #(.DATA_W(DATA_W)) u_soft (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (soft_we),
    .wdata_i(wdata_i),
    .mask_o (soft_q)
  );

  ucr_lock_mask #(.DATA_W(DATA_W)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (lock_we),
    .wdata_i(wdata_i),
    .mask_o (lock_q)
  );

  assign status_o = soft_q | lock_q;

  ucr_ctx_check #(.DATA_W(DATA_W)) u_chk_ctx (
    .valid_i   (chk_valid_i),
    .ctx_i     (chk_ctx_i),
    .restrict_i(status_o),
    .viol_o    (chk_viol_o)
  );
endmodule

// File: rtl/ucr_guard_chk.sv
module ucr_guard_chk
  import ucr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wp_en_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] status_o,
  input logic              chk_valid_i,
  input logic [DATA_W-1:0] chk_ctx_i,
  input logic              chk_viol_o,
  input logic [DATA_W-1:0] soft_q,
  input logic [DATA_W-1:0] lock_q
);
  logic wr_any;
  logic wr_other;
  assign wr_any   = req_i && we_i;
  assign wr_other = wr_any && (addr_i != ADDR_W'(OFF_SOFT)) && (addr_i != ADDR_W'(OFF_LOCK));

  assert_soft_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_any && !wp_en_i && addr_i == ADDR_W'(OFF_SOFT)) |=> (soft_q == $past(wdata_i)));

  assert_wp_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_en_i |=> ($stable(soft_q) && $stable(lock_q)));

  assert_lock_accum_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_any && !wp_en_i && addr_i == ADDR_W'(OFF_LOCK)) |=> (lock_q == ($past(lock_q) | $past(wdata_i))));

  assert_lock_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  assert_status_cover_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & lock_q) == lock_q) && ((status_o & soft_q) == soft_q));

  assert_other_wr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_other |=> ($stable(soft_q) && $stable(lock_q)));

  assert_no_viol_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chk_valid_i || chk_ctx_i == '0) |-> !chk_viol_o);
endmodule

bind ucr_guard ucr_guard_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_guard_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wp_en_i    (wp_en_i),
  .req_i      (req_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .status_o   (status_o),
  .chk_valid_i(chk_valid_i),
  .chk_ctx_i  (chk_ctx_i),
  .chk_viol_o (chk_viol_o),
  .soft_q     (soft_q),
  .lock_q     (lock_q)
);

// File: tb/tb_ucr_guard.sv
`timescale 1ns/1ps
module tb_ucr_guard;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [DW-1:0] status;
  logic          cv = 1'b0;
  logic [DW-1:0] ctx = '0;
  logic          viol;

  int n_tests = 0;
  int n_fail  = 0;
  bit [DW-1:0] m_soft;
  bit [DW-1:0] m_lock;

  always #2.5 clk = ~clk;

  ucr_guard #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wp_en_i(wp), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .status_o(status),
    .chk_valid_i(cv), .chk_ctx_i(ctx), .chk_viol_o(viol)
  );

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_soft <= '0;
      m_lock <= '0;
    end else if (req && we && !wp) begin
      if (addr == 4'h0) m_soft <= wdata;
      if (addr == 4'h4) m_lock <= m_lock | wdata;
    end
  end

  function automatic bit [DW-1:0] m_read();
    if (!(req && !we)) return '0;
    case (addr)
      4'h0:    return m_soft;
      4'h4:    return m_lock;
      4'h8:    return m_soft | m_lock;
      default: return '0;
    endcase
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // drive on falling edge, sample 1 ns later
  task automatic cyc(bit r, bit w, bit [AW-1:0] a, bit [DW-1:0] d,
                     bit c, bit [DW-1:0] x, string tag);
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d; cv = c; ctx = x;
    #1;
    check(tag, rdata, m_read());
    check("R6", status, m_soft | m_lock);
    check("R8", {31'd0, viol}, {31'd0, c && ((x & (m_soft | m_lock)) != 0)});
  endtask

  task automatic wr(bit [AW-1:0] a, bit [DW-1:0] d, string tag);
    cyc(1, 1, a, d, 0, '0, tag);
  endtask
  task automatic rd(bit [AW-1:0] a, string tag);
    cyc(1, 0, a, '0, 0, '0, tag);
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    // R1 reset state
    rd(4'h0, "R1"); rd(4'h4, "R1"); rd(4'h8, "R1");
    check("R1", status, '0);
    // R2 soft set then clear
    wr(4'h0, 32'hA5A5_0F0F, "R2");
    rd(4'h0, "R2");
    check("R2", rdata, 32'hA5A5_0F0F);
    wr(4'h0, 32'h0000_0F00, "R2");
    rd(4'h0, "R2");
    check("R2", rdata, 32'h0000_0F00);
    // R4 lock accumulates, zeros do not clear
    wr(4'h4, 32'h0000_00F0, "R4");
    wr(4'h4, 32'h0000_000F, "R4");
    rd(4'h4, "R4");
    check("R4", rdata, 32'h0000_00FF);
    wr(4'h4, 32'h0000_0000, "R5");
    rd(4'h4, "R5");
    check("R5", rdata, 32'h0000_00FF);
    // R6 status OR
    rd(4'h8, "R6");
    check("R6", rdata, 32'h0000_0FFF);
    // R3 write protect
    wp = 1'b1;
    wr(4'h0, 32'hFFFF_FFFF, "R3");
    wr(4'h4, 32'hFFFF_0000, "R3");
    rd(4'h0, "R3");
    check("R3", rdata, 32'h0000_0F00);
    rd(4'h4, "R3");
    check("R3", rdata, 32'h0000_00FF);
    wp = 1'b0;
    // R7 status/undefined offsets
    wr(4'h8, 32'hFFFF_FFFF, "R7");
    wr(4'hC, 32'hFFFF_FFFF, "R7");
    wr(4'h2, 32'hFFFF_FFFF, "R7");
    rd(4'h8, "R7");
    check("R7", rdata, 32'h0000_0FFF);
    rd(4'hC, "R7");
    check("R7", rdata, '0);
    // R9 no read -> zero
    cyc(0, 0, 4'h0, '0, 0, '0, "R9");
    check("R9", rdata, '0);
    cyc(1, 1, 4'h4, 32'h0000_0100, 0, '0, "R9");
    check("R9", rdata, '0);
    // R5 soft clear cannot drop lock bits
    wr(4'h0, 32'h0, "R5");
    rd(4'h8, "R5");
    check("R5", rdata, 32'h0000_01FF);
    // R8 context checks
    cyc(0, 0, 4'h0, '0, 1, 32'h0000_0001, "R8");
    check("R8", {31'd0, viol}, 32'd1);
    cyc(0, 0, 4'h0, '0, 1, 32'hFFFF_FE00, "R8");
    check("R8", {31'd0, viol}, 32'd0);
    cyc(0, 0, 4'h0, '0, 0, 32'hFFFF_FFFF, "R8");
    check("R8", {31'd0, viol}, 32'd0);
    cyc(0, 0, 4'h0, '0, 1, 32'h8000_0100, "R8");
    check("R8", {31'd0, viol}, 32'd1);
    // pattern sweep of lock bits
    for (int i = 0; i < 40; i++) begin
      wr(4'h4, 32'h1 << (i % 32), "R4");
      cyc(1, 0, 4'h8, '0, 1, 32'h1 << ((i * 7) % 32), "R6");
    end
    // R5 reset wins over a simultaneous lock write
    @(negedge clk);
    req = 1; we = 1; addr = 4'h4; wdata = 32'hDEAD_BEEF; cv = 0;
    #2 rst_n = 1'b0;
    #1;
    check("R5", status, '0);
    @(negedge clk);
    req = 0; we = 0;
    #1 rst_n = 1'b1;
    rd(4'h4, "R5");
    check("R5", rdata, '0);
    rd(4'h8, "R1");
    check("R1", rdata, '0);
    wr(4'h0, 32'h0000_0003, "R2");
    cyc(0, 0, 4'h0, '0, 1, 32'h0000_0002, "R8");
    check("R8", {31'd0, viol}, 32'd1);
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule